// File: doc/BRIEF.md
# Request Packet Receive Parser

This block sits behind a link's receive stream and takes in memory request packets that have a four-word header. The stream delivers one 32-bit word per clock, qualified by a valid strobe and closed by a last strobe. The parser tracks where each word falls in the packet and checks the format and type fields of the first header word. It latches the two header words, the two address words and, for writes, one payload word into registers that downstream logic reads directly.

A memory read does not finish inside the parser. When a read packet is accepted, the block raises a request toward the transmit side. It then withholds ready, and drops a non-posted-credit indication, until the transmit side returns a one-cycle done pulse. Packets marked with the error-forward flag, packets that hit no base address window, and packets of any other kind are consumed up to their last word without touching any register. A 3-bit code exposes the parser's position for debug.

Top module: `tlp_req_parser`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it, ready and np_ok are high, rd_req is low, state_dbg is 0 and all five capture registers are zero. A reset in the middle of a packet returns the parser to expecting header word 0.
- R2: Header word 0 is classed from bits 30:29 (format) and 28:24 (type). Format 2'b11 with type 5'b00000 is a write. Format 2'b01 with type 5'b00000 is a read. Any other combination is handled as in R7.
- R3: In an accepted write, the beats in order load hdr0_q, hdr1_q, addr_hi_q, addr_lo_q and data_q. Each value is visible in the cycle after its beat is taken.
- R4: A cycle with rx_valid low between words of a packet leaves the position unchanged. The next valid word goes to the next field, with no word lost or repeated.
- R5: rd_req rises in the cycle after the last word of an accepted four-word read is taken. It stays high until rd_done is sampled high, and falls in the following cycle. A read updates the four header and address registers but not data_q.
- R6: While rd_req is high, rx_ready and np_ok are low and no word is taken. A word presented in that time stays pending, leaves every capture register unchanged, and is taken in the first cycle after the done pulse clears rd_req.
- R7: When err_fwd is high or bar_hit is all zero on the header-word-0 beat, or the packet is of neither kind in R2, every word up to last is consumed with no register update and no rd_req.
- R8: Words beyond the end of a packet's layout (past the data word of a write, or past the low address word of a read) are drained until last. data_q keeps the first data word.
- R9: state_dbg reads 0 when expecting header word 0, then 1 for header word 1, 2 for the high address, 3 for the low address, 4 for the data word, 5 while draining, and 6 while a read is pending.
- R10: A done pulse with no read pending has no effect: rd_req stays low and rx_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| rx_data | input | 32 | Stream word |
| rx_valid | input | 1 | Stream word is valid |
| rx_last | input | 1 | Word is the final one of its packet |
| rx_ready | output | 1 | Parser takes the word this cycle |
| err_fwd | input | 1 | Packet is flagged as error-forwarded (sampled on header word 0) |
| bar_hit | input | 7 | Base address window hit vector (sampled on header word 0) |
| rd_req | output | 1 | Read request toward the transmit side |
| rd_done | input | 1 | One-cycle completion pulse from the transmit side |
| np_ok | output | 1 | Parser can accept a non-posted request |
| hdr0_q | output | 32 | Captured header word 0 |
| hdr1_q | output | 32 | Captured header word 1 |
| addr_hi_q | output | 32 | Captured upper address word |
| addr_lo_q | output | 32 | Captured lower address word |
| data_q | output | 32 | Captured payload word |
| state_dbg | output | 3 | Parser position code |

## Verification
Releasing a pending read and taking in a new packet can happen in the same cycle. To provoke this, the bench presents the first word of a write while a read is pending and holds rx_valid high through the stall, so the done pulse arrives with that word still on the bus. Before the pulse, the bench checks that the pending code, low ready and unchanged registers persist. After the pulse, rd_req must fall in the next cycle and the waiting word must be taken exactly once. The scoreboard then confirms that the write's five fields land in their registers.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;

  localparam int FMT_HI  = 30;
  localparam int FMT_LO  = 29;
  localparam int TYPE_HI = 28;
  localparam int TYPE_LO = 24;
  localparam int CLS_W   = FMT_HI - TYPE_LO + 1;

  localparam logic [1:0] FMT_4DW_DATA   = 2'b11;
  localparam logic [1:0] FMT_4DW_NODATA = 2'b01;
  localparam logic [4:0] TYPE_MEM       = 5'b00000;

  typedef enum logic [2:0] {
    POS_HDR0    = 3'd0,
    POS_HDR1    = 3'd1,
    POS_ADDR_HI = 3'd2,
    POS_ADDR_LO = 3'd3,
    POS_DATA    = 3'd4,
    POS_DRAIN   = 3'd5
  } pos_e;

  localparam logic [2:0] DBG_RD_WAIT = 3'd6;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_READ  = 2'd2
  } kind_e;

  function automatic kind_e classify(input logic [CLS_W-1:0] cls);
    logic [1:0] fmt;
    logic [4:0] typ;
    fmt = cls[CLS_W-1 -: 2];
    typ = cls[4:0];
    if (typ == TYPE_MEM && fmt == FMT_4DW_DATA)        return KIND_WRITE;
    else if (typ == TYPE_MEM && fmt == FMT_4DW_NODATA) return KIND_READ;
    else                                               return KIND_NONE;
  endfunction

endpackage

// File: rtl/tlp_beat_fsm.sv
module tlp_beat_fsm
  import tlp_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  valid_i,
  input  logic  ready_i,
  input  logic  last_i,
  input  kind_e kind_now_i,
  input  logic  keep_now_i,
  output pos_e  pos_o,
  output logic  keep_o,
  output logic  rd_fire_o
);

  pos_e  pos_q, pos_d;
  kind_e kind_q;
  logic  keep_q;
  logic  beat;
  logic  hdr_en;

  assign beat   = valid_i & ready_i;
  assign hdr_en = beat & (pos_q == POS_HDR0);

  always_comb begin
    pos_d = pos_q;
    if (last_i) begin
      pos_d = POS_HDR0;
    end else begin
      case (pos_q)
        POS_HDR0:    pos_d = POS_HDR1;
        POS_HDR1:    pos_d = POS_ADDR_HI;
        POS_ADDR_HI: pos_d = POS_ADDR_LO;
        POS_ADDR_LO: pos_d = (kind_q == KIND_WRITE) ? POS_DATA : POS_DRAIN;
        default:     pos_d = POS_DRAIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_HDR0;
      kind_q <= KIND_NONE;
      keep_q <= 1'b0;
    end else begin
      if (beat) pos_q <= pos_d;
      if (hdr_en) begin
        kind_q <= kind_now_i;
        keep_q <= keep_now_i;
      end
    end
  end

  assign pos_o     = pos_q;
  assign keep_o    = keep_q;
  assign rd_fire_o = beat & last_i & (pos_q == POS_ADDR_LO) & keep_q & (kind_q == KIND_READ);

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(pos_q)); // R4
  AST_STALL_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> pos_q == POS_HDR0); // R6
  AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    beat && last_i |=> pos_q == POS_HDR0); // R8

endmodule

// File: rtl/tlp_field_regs.sv
module tlp_field_regs
  import tlp_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_i,
  input  pos_e              pos_i,
  input  logic              keep_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] hdr0_o,
  output logic [DATA_W-1:0] hdr1_o,
  output logic [DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0] addr_lo_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int NFIELD = 5;

  logic              take;
  logic [NFIELD-1:0] en;
  logic [DATA_W-1:0] fld_q [NFIELD];

  assign take = beat_i & keep_i;

  always_comb begin
    en = '0;
    if (take) begin
      case (pos_i)
        POS_HDR0:    en[0] = 1'b1;
        POS_HDR1:    en[1] = 1'b1;
        POS_ADDR_HI: en[2] = 1'b1;
        POS_ADDR_LO: en[3] = 1'b1;
        POS_DATA:    en[4] = 1'b1;
        default:     en    = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fld_q[i] <= '0;
      else if (en[i]) fld_q[i] <= din_i;
    end
  end

  assign hdr0_o    = fld_q[0];
  assign hdr1_o    = fld_q[1];
  assign addr_hi_o = fld_q[2];
  assign addr_lo_o = fld_q[3];
  assign data_o    = fld_q[4];

  AST_DROP_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_i && !keep_i |=> $stable({hdr0_o, hdr1_o, addr_hi_o, addr_lo_o, data_o})); // R7
  AST_DATA_ONLY_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pos_i != POS_DATA |=> $stable(data_o)); // R8

endmodule

// File: rtl/tlp_rd_tracker.sv
module tlp_rd_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic done_i,
  output logic pending_o
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (fire_i)      pend_d = 1'b1;
    else if (done_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending_o = pend_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !done_i |=> pend_q); // R5
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && done_i |=> !pend_q); // R5
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && !fire_i |=> !pend_q); // R10

endmodule

// File: rtl/tlp_req_parser.sv
module tlp_req_parser
  import tlp_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BAR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  output logic              rx_ready,
  input  logic              err_fwd,
  input  logic [BAR_W-1:0]  bar_hit,
  output logic              rd_req,
  input  logic              rd_done,
  output logic              np_ok,
  output logic [DATA_W-1:0] hdr0_q,
  output logic [DATA_W-1:0] hdr1_q,
  output logic [DATA_W-1:0] addr_hi_q,
  output logic [DATA_W-1:0] addr_lo_q,
  output logic [DATA_W-1:0] data_q,
  output logic [2:0]        state_dbg
);

  kind_e kind_now;
  logic  keep_now;
  pos_e  pos;
  logic  keep_q;
  logic  keep_eff;
  logic  rd_fire;
  logic  pending;
  logic  beat;

  assign kind_now = classify(rx_data[FMT_HI:TYPE_LO]);
  assign keep_now = ~err_fwd & (|bar_hit) & (kind_now != KIND_NONE);
  assign keep_eff = (pos == POS_HDR0) ? keep_now : keep_q;
  assign rx_ready = ~pending;
  assign np_ok    = ~pending;
  assign rd_req   = pending;
  assign beat     = rx_valid & rx_ready;

  tlp_beat_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (rx_valid),
    .ready_i    (rx_ready),
    .last_i     (rx_last),
    .kind_now_i (kind_now),
    .keep_now_i (keep_now),
    .pos_o      (pos),
    .keep_o     (keep_q),
    .rd_fire_o  (rd_fire)
  );

  tlp_field_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_i    (beat),
    .pos_i     (pos),
    .keep_i    (keep_eff),
    .din_i     (rx_data),
    .hdr0_o    (hdr0_q),
    .hdr1_o    (hdr1_q),
    .addr_hi_o (addr_hi_q),
    .addr_lo_o (addr_lo_q),
    .data_o    (data_q)
  );

  tlp_rd_tracker u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (rd_fire),
    .done_i    (rd_done),
    .pending_o (pending)
  );

  assign state_dbg = pending ? DBG_RD_WAIT : pos;

  AST_STATE_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    state_dbg != 3'd7); // R9
  AST_PENDING_BLOCKS_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_done |=> !rx_ready && !np_ok); // R6

endmodule

// File: tb/tb_tlp_req_parser.sv
module tb_tlp_req_parser;

  logic        clk;
  logic        rst_n;
  logic [31:0] rx_data;
  logic        rx_valid, rx_last, rx_ready, err_fwd;
  logic [6:0]  bar_hit;
  logic        rd_req, rd_done, np_ok;
  logic [31:0] hdr0_q, hdr1_q, addr_hi_q, addr_lo_q, data_q;
  logic [2:0]  state_dbg;

  int checks   = 0;
  int failures = 0;

  tlp_req_parser dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_ready(rx_ready), .err_fwd(err_fwd), .bar_hit(bar_hit), .rd_req(rd_req),
    .rd_done(rd_done), .np_ok(np_ok), .hdr0_q(hdr0_q), .hdr1_q(hdr1_q),
    .addr_hi_q(addr_hi_q), .addr_lo_q(addr_lo_q), .data_q(data_q), .state_dbg(state_dbg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] h0, h1, ah, al, d;
    logic        rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        cur;
  logic        end_seen = 1'b0;
  logic [31:0] m0 = '0, m1 = '0, m2 = '0, m3 = '0, m4 = '0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Monitor: after each accepted last word, compare against the scoreboard
  always @(negedge clk) begin
    if (end_seen) begin
      if (sb.size() == 0) begin
        chk("R3 scoreboard empty", 32'd1, 32'd0);
      end else begin
        cur = sb.pop_front();
        chk({cur.tag, " hdr0"},    hdr0_q,    cur.h0);
        chk({cur.tag, " hdr1"},    hdr1_q,    cur.h1);
        chk({cur.tag, " addr_hi"}, addr_hi_q, cur.ah);
        chk({cur.tag, " addr_lo"}, addr_lo_q, cur.al);
        chk({cur.tag, " data"},    data_q,    cur.d);
        chk({cur.tag, " rd_req"},  {31'd0, rd_req}, {31'd0, cur.rd});
      end
    end
    end_seen = rst_n && rx_valid && rx_ready && rx_last;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [31:0] w, input logic l);
    logic acc;
    rx_valid = 1'b1;
    rx_data  = w;
    rx_last  = l;
    do begin
      @(negedge clk);
      acc = rx_ready;
      step();
    end while (!acc);
  endtask

  function automatic int kind_of(input logic [31:0] w);
    if (w[28:24] == 5'd0 && w[30:29] == 2'b11) return 1;
    if (w[28:24] == 5'd0 && w[30:29] == 2'b01) return 2;
    return 0;
  endfunction

  // Driver: computes the expected result, pushes it, then drives the words
  task automatic send_pkt(input logic [31:0] w [8], input int n, input int gap,
                          input logic err, input logic [6:0] bar, input string tag);
    exp_t e;
    int   k;
    logic keep;
    k    = kind_of(w[0]);
    keep = !err && (bar != 0) && (k != 0);
    if (keep) begin
      m0 = w[0];
      if (n > 1) m1 = w[1];
      if (n > 2) m2 = w[2];
      if (n > 3) m3 = w[3];
      if (k == 1 && n > 4) m4 = w[4];
    end
    e.h0 = m0; e.h1 = m1; e.ah = m2; e.al = m3; e.d = m4;
    e.rd  = keep && (k == 2) && (n == 4);
    e.tag = tag;
    sb.push_back(e);
    err_fwd = err;
    bar_hit = bar;
    for (int i = 0; i < n; i++) begin
      put(w[i], i == n - 1);
      if (gap > 0 && i < n - 1) begin
        rx_valid = 1'b0;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (g == 0)
            chk("R9 state during gap", {29'd0, state_dbg},
                (i < 3) ? i + 1 : (i == 3 && k == 1) ? 32'd4 : 32'd5);
          step();
        end
      end
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    err_fwd  = 1'b0;
  endtask

  task automatic pulse_done();
    rd_done = 1'b1;
    step();
    rd_done = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_data = '0; rx_valid = 1'b0; rx_last = 1'b0;
    err_fwd = 1'b0; bar_hit = 7'h01; rd_done = 1'b0;
    repeat (3) step();
    @(negedge clk);
    chk("R1 ready in reset", {31'd0, rx_ready}, 32'd1);
    chk("R1 np_ok in reset", {31'd0, np_ok}, 32'd1);
    chk("R1 rd_req in reset", {31'd0, rd_req}, 32'd0);
    chk("R1 state in reset", {29'd0, state_dbg}, 32'd0);
    chk("R1 hdr0 in reset", hdr0_q, 32'd0);
    step();
    rst_n = 1'b1;
    step();

    // R2 R3: contiguous write
    send_pkt('{32'h6000_0001, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0004,
               32'h0000_0001, 0, 0, 0}, 5, 0, 1'b0, 7'h01, "R3 write");
    // R4: write with valid gaps
    send_pkt('{32'h6000_0001, 32'h1234_00AA, 32'h0000_0010, 32'h0000_0044,
               32'hCAFE_0002, 0, 0, 0}, 5, 2, 1'b0, 7'h04, "R4 gapped write");
    // R5: read
    send_pkt('{32'h2000_0001, 32'h5555_0011, 32'h0000_0020, 32'h0000_0080,
               0, 0, 0, 0}, 4, 0, 1'b0, 7'h01, "R5 read");
    @(negedge clk);
    chk("R6 ready low while pending", {31'd0, rx_ready}, 32'd0);
    chk("R6 np_ok low while pending", {31'd0, np_ok}, 32'd0);
    chk("R9 state read pending", {29'd0, state_dbg}, 32'd6);
    repeat (3) step();
    @(negedge clk);
    chk("R5 rd_req held", {31'd0, rd_req}, 32'd1);
    step();

    // R6: word offered during the stall; done arrives while it waits
    fork
      send_pkt('{32'h6000_0001, 32'hAAAA_0001, 32'h0000_0030, 32'h0000_00C0,
                 32'hBEEF_0003, 0, 0, 0}, 5, 0, 1'b0, 7'h02, "R6 stalled write");
      begin
        repeat (5) step();
        @(negedge clk);
        chk("R6 state still pending", {29'd0, state_dbg}, 32'd6);
        chk("R6 ready low during stall", {31'd0, rx_ready}, 32'd0);
        chk("R6 hdr0 unchanged during stall", hdr0_q, 32'h2000_0001);
        step();
        pulse_done();
        @(negedge clk);
        chk("R5 rd_req falls after done", {31'd0, rd_req}, 32'd0);
        chk("R6 np_ok restored", {31'd0, np_ok}, 32'd1);
      end
    join
    step();

    // R7: error-forwarded write, no-hit read, unsupported kind
    send_pkt('{32'h6000_0001, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333,
               32'h4444_4444, 0, 0, 0}, 5, 1, 1'b1, 7'h01, "R7 err_fwd write");
    send_pkt('{32'h2000_0001, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333,
               0, 0, 0, 0}, 4, 0, 1'b0, 7'h00, "R7 no-hit read");
    @(negedge clk);
    chk("R7 ready after dropped read", {31'd0, rx_ready}, 32'd1);
    step();
    send_pkt('{32'h4400_0001, 32'h7777_7777, 32'h8888_8888, 32'h9999_9999,
               0, 0, 0, 0}, 4, 0, 1'b0, 7'h01, "R7 other kind");

    // R8: write with two extra words drained
    send_pkt('{32'h6000_0001, 32'h0BAD_0001, 32'h0000_0040, 32'h0000_0100,
               32'hD00D_0004, 32'hEEEE_EEEE, 32'hFFFF_FFFF, 0}, 7, 1, 1'b0, 7'h01, "R8 drain");

    // R10: done with nothing pending
    pulse_done();
    @(negedge clk);
    chk("R10 rd_req stays low", {31'd0, rd_req}, 32'd0);
    chk("R10 ready stays high", {31'd0, rx_ready}, 32'd1);
    step();

    // R4 R5: gapped read then release
    send_pkt('{32'h2000_0001, 32'h0C0C_0C0C, 32'h0000_0050, 32'h0000_0140,
               0, 0, 0, 0}, 4, 3, 1'b0, 7'h40, "R5 gapped read");
    step();
    pulse_done();
    @(negedge clk);
    chk("R5 released", {31'd0, rd_req}, 32'd0);
    step();

    // R1: reset in the middle of a packet
    err_fwd = 1'b0; bar_hit = 7'h01;
    put(32'h6000_0001, 1'b0);
    put(32'h0101_0101, 1'b0);
    rx_valid = 1'b0;
    rst_n = 1'b0;
    m0 = '0; m1 = '0; m2 = '0; m3 = '0; m4 = '0;
    @(negedge clk);
    chk("R1 state after mid reset", {29'd0, state_dbg}, 32'd0);
    chk("R1 hdr0 after mid reset", hdr0_q, 32'd0);
    step();
    rst_n = 1'b1;
    step();
    send_pkt('{32'h6000_0001, 32'h0202_0202, 32'h0000_0060, 32'h0000_0180,
               32'h1357_9BDF, 0, 0, 0}, 5, 0, 1'b0, 7'h01, "R1 resume");
    repeat (3) step();
    chk("R3 scoreboard drained", sb.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule